// File: doc/BRIEF.md
# Consecutive Collision Auto-Partition

This block sits beside one repeater port and guards the shared segment against a port that keeps colliding. The repeater core reports each packet that ends on the port with a single-cycle strobe, plus three qualifiers for that packet:
- whether a collision occurred,
- whether the port was the transmitter,
- whether the packet reached 512 bits.

The block keeps a count of back-to-back collided packets. When that count reaches a selectable limit, the block isolates the port.

While the port is isolated, its receive activity is not forwarded to the repeater core. Its transmit path is untouched, so traffic still goes out of the port. The port rejoins when a packet of 512 bits or more goes out of it with no collision.

A configuration input selects a limit of 32 or 64. A second configuration input turns the whole function off. Each repeater port gets its own instance, so ports are fully independent.

Top module: `port_autopart`

## Requirements
- R1: After synchronous reset the port is connected (`partitioned`=0, `partition_event`=0) and the consecutive count is zero. From reset, exactly 32 collided packets are needed to partition with the low limit.
- R2: With `cfg_limit_hi`=0 the port partitions on the strobe of the 32nd consecutive collided packet and not on the 31st. `partitioned` is high in the cycle after that strobe.
- R3: With `cfg_limit_hi`=1 the port partitions on the 64th consecutive collided packet and not on the 63rd.
- R4: While connected, any strobed packet with `pkt_coll`=0 resets the count to zero, whatever its direction or length.
- R5: `partition_event` is high for exactly one cycle, the same cycle in which `partitioned` first rises.
- R6: `rx_fwd` equals `rx_active` while connected and is 0 while partitioned.
- R7: A partitioned port reconnects in the cycle after a strobe with `pkt_coll`=0, `pkt_tx`=1 and `pkt_long`=1. That strobe also clears the count, so 32 more collisions (low limit) are needed to partition again.
- R8: While partitioned, none of the following reconnects the port: a collision-free transmitted packet with `pkt_long`=0, a collision-free received packet (`pkt_tx`=0), or a collided packet.
- R9: With `cfg_disable`=1 the port never partitions. Raising `cfg_disable` while partitioned clears the partition and the count at the next clock edge.
- R10: `pkt_coll`, `pkt_tx` and `pkt_long` have no effect in cycles where `pkt_end`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pkt_end | input | 1 | One-cycle strobe: a packet on this port ended |
| pkt_coll | input | 1 | The ending packet saw a collision |
| pkt_tx | input | 1 | The port was transmitting the ending packet |
| pkt_long | input | 1 | The ending packet was at least 512 bits |
| cfg_limit_hi | input | 1 | 0: limit 32, 1: limit 64 |
| cfg_disable | input | 1 | 1: auto-partition off |
| rx_active | input | 1 | Receive activity from the port |
| rx_fwd | output | 1 | Receive activity passed to the repeater core |
| partitioned | output | 1 | Port is isolated |
| partition_event | output | 1 | One-cycle pulse on entering isolation |

## Verification
The count is not visible at the ports. Its value is exposed only through the strobe on which `partitioned` rises. A count that failed to clear, skipped, or drifted therefore shows up as partitioning one packet early or late, on the very strobe where the limit falls.

A wrong state-machine state shows within one cycle on `rx_fwd` and `partitioned`. The scenarios place clean packets just before the limit and probe each non-reconnecting packet type while isolated. They also re-count after every reconnect, so a corrupted count surfaces within one run of collisions.

// File: rtl/ap_pkg.sv
package ap_pkg;

    typedef enum logic {
        ST_JOINED   = 1'b0,
        ST_ISOLATED = 1'b1
    } part_state_e;

    typedef struct packed {
        logic done;
        logic coll;
        logic tx;
        logic long_ok;
    } pkt_ev_t;

    function automatic int unsigned cnt_width(input int unsigned max_val);
        return $clog2(max_val + 2);
    endfunction

endpackage

// File: rtl/ap_coll_counter.sv
module ap_coll_counter #(
    parameter int unsigned THR_HI = 64,
    parameter int unsigned CW     = ap_pkg::cnt_width(THR_HI)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ev_done,
    input  logic          ev_coll,
    input  logic          hold,
    input  logic          clear,
    input  logic [CW-1:0] limit,
    output logic          hit
);
    logic [CW-1:0] cnt;
    logic [CW-1:0] cnt_nxt;

    always_comb begin
        cnt_nxt = cnt + CW'(1);
        hit     = ev_done && ev_coll && !hold && !clear && (cnt_nxt >= limit);
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
        end else if (ev_done && !hold) begin
            if (ev_coll) begin
                cnt <= hit ? limit : cnt_nxt;
            end else begin
                cnt <= '0;
            end
        end
    end

    // R3
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(THR_HI));

    // R8
    cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (hold && !clear) |=> $stable(cnt));

    // R10
    cnt_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!ev_done && !clear) |=> $stable(cnt));
endmodule

// File: rtl/ap_part_fsm.sv
module ap_part_fsm
    import ap_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  pkt_ev_t ev,
    input  logic    hit,
    input  logic    disable_i,
    output logic    rejoin,
    output logic    isolated,
    output logic    enter_pulse
);
    part_state_e state;

    always_comb begin
        isolated = (state == ST_ISOLATED);
        rejoin   = isolated && ev.done && !ev.coll && ev.tx && ev.long_ok;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_JOINED;
            enter_pulse <= 1'b0;
        end else begin
            enter_pulse <= 1'b0;
            if (disable_i) begin
                state <= ST_JOINED;
            end else begin
                unique case (state)
                    ST_JOINED: begin
                        if (hit) begin
                            state       <= ST_ISOLATED;
                            enter_pulse <= 1'b1;
                        end
                    end
                    ST_ISOLATED: begin
                        if (rejoin) state <= ST_JOINED;
                    end
                    default: state <= ST_JOINED;
                endcase
            end
        end
    end

    // R5
    enter_once_chk: assert property (@(posedge clk) disable iff (rst)
        enter_pulse |-> (isolated && !$past(isolated)));

    // R5
    enter_single_chk: assert property (@(posedge clk) disable iff (rst)
        enter_pulse |=> !enter_pulse);

    // R9
    off_clears_chk: assert property (@(posedge clk) disable iff (rst)
        disable_i |=> !isolated);

    // R8
    stay_isolated_chk: assert property (@(posedge clk) disable iff (rst)
        (isolated && !disable_i && !(ev.done && !ev.coll && ev.tx && ev.long_ok))
        |=> isolated);
endmodule

// File: rtl/port_autopart.sv
module port_autopart
    import ap_pkg::*;
#(
    parameter int unsigned THR_LO = 32,
    parameter int unsigned THR_HI = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic pkt_end,
    input  logic pkt_coll,
    input  logic pkt_tx,
    input  logic pkt_long,
    input  logic cfg_limit_hi,
    input  logic cfg_disable,
    input  logic rx_active,
    output logic rx_fwd,
    output logic partitioned,
    output logic partition_event
);
    localparam int unsigned CW = cnt_width(THR_HI);
    localparam logic [CW-1:0] LIM_LO = CW'(THR_LO);
    localparam logic [CW-1:0] LIM_HI = CW'(THR_HI);

    pkt_ev_t       ev;
    logic [CW-1:0] limit;
    logic          hit;
    logic          rejoin;
    logic          isolated;

    always_comb begin
        ev    = '{done: pkt_end, coll: pkt_coll, tx: pkt_tx, long_ok: pkt_long};
        limit = cfg_limit_hi ? LIM_HI : LIM_LO;
    end

    ap_coll_counter #(.THR_HI(THR_HI), .CW(CW)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .ev_done (ev.done),
        .ev_coll (ev.coll),
        .hold    (isolated),
        .clear   (cfg_disable || rejoin),
        .limit   (limit),
        .hit     (hit)
    );

    ap_part_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .ev          (ev),
        .hit         (hit),
        .disable_i   (cfg_disable),
        .rejoin      (rejoin),
        .isolated    (isolated),
        .enter_pulse (partition_event)
    );

    always_comb begin
        partitioned = isolated;
        rx_fwd      = rx_active && !isolated;
    end

    // R6
    rx_block_chk: assert property (@(posedge clk) disable iff (rst)
        partitioned |-> !rx_fwd);

    // R7
    rejoin_chk: assert property (@(posedge clk) disable iff (rst)
        (partitioned && pkt_end && !pkt_coll && pkt_tx && pkt_long) |=> !partitioned);
endmodule

// File: tb/port_autopart_test.sv
module port_autopart_test;
    logic clk = 1'b0;
    logic rst, pkt_end, pkt_coll, pkt_tx, pkt_long, cfg_limit_hi, cfg_disable, rx_active;
    logic rx_fwd, partitioned, partition_event;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    port_autopart uut (
        .clk(clk), .rst(rst), .pkt_end(pkt_end), .pkt_coll(pkt_coll), .pkt_tx(pkt_tx),
        .pkt_long(pkt_long), .cfg_limit_hi(cfg_limit_hi), .cfg_disable(cfg_disable),
        .rx_active(rx_active), .rx_fwd(rx_fwd), .partitioned(partitioned),
        .partition_event(partition_event)
    );

    task automatic chk(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    // outputs sampled at the negedge after the strobe's posedge
    task automatic pkt(input logic c, input logic t, input logic l);
        @(negedge clk);
        pkt_end = 1'b1; pkt_coll = c; pkt_tx = t; pkt_long = l;
        @(negedge clk);
        pkt_end = 1'b0; pkt_coll = 1'b0; pkt_tx = 1'b0; pkt_long = 1'b0;
    endtask

    task automatic colls(input int n);
        for (int i = 0; i < n; i++) pkt(1'b1, 1'b0, 1'b1);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; cfg_disable = 1'b0; cfg_limit_hi = 1'b0;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk(partitioned, 1'b0, "R1 partitioned after reset");
        chk(partition_event, 1'b0, "R1 event after reset");
        colls(31);
        chk(partitioned, 1'b0, "R1 zero count: 31 collisions");
    endtask

    task automatic t_limit_lo();
        do_reset();
        rx_active = 1'b1;
        colls(31);
        chk(partitioned, 1'b0, "R2 not at 31");
        #1 chk(rx_fwd, 1'b1, "R6 rx forwarded when connected");
        colls(1);
        chk(partitioned, 1'b1, "R2 partitioned at 32");
        chk(partition_event, 1'b1, "R5 event pulse");
        chk(rx_fwd, 1'b0, "R6 rx blocked");
        @(negedge clk);
        chk(partition_event, 1'b0, "R5 pulse one cycle");
        chk(partitioned, 1'b1, "R5 stays partitioned");
        colls(3);
        chk(partition_event, 1'b0, "R5 no pulse when already partitioned");
        rx_active = 1'b0;
    endtask

    task automatic t_limit_hi();
        do_reset();
        cfg_limit_hi = 1'b1;
        colls(63);
        chk(partitioned, 1'b0, "R3 not at 63");
        colls(1);
        chk(partitioned, 1'b1, "R3 partitioned at 64");
        cfg_limit_hi = 1'b0;
    endtask

    task automatic t_clean_resets();
        do_reset();
        colls(31); pkt(1'b0, 1'b0, 1'b0);
        colls(31);
        chk(partitioned, 1'b0, "R4 short rx clean packet resets count");
        pkt(1'b0, 1'b1, 1'b1);
        colls(31);
        chk(partitioned, 1'b0, "R4 long tx clean packet resets count");
        colls(1);
        chk(partitioned, 1'b1, "R4 32 after clean packet partitions");
    endtask

    task automatic t_rejoin();
        do_reset();
        colls(32);
        chk(partitioned, 1'b1, "R8 setup partitioned");
        pkt(1'b0, 1'b1, 1'b0);
        chk(partitioned, 1'b1, "R8 short tx keeps partition");
        pkt(1'b0, 1'b0, 1'b1);
        chk(partitioned, 1'b1, "R8 long rx keeps partition");
        pkt(1'b1, 1'b1, 1'b1);
        chk(partitioned, 1'b1, "R8 collided tx keeps partition");
        pkt(1'b0, 1'b1, 1'b1);
        chk(partitioned, 1'b0, "R7 long clean tx reconnects");
        colls(31);
        chk(partitioned, 1'b0, "R7 count cleared at reconnect");
        colls(1);
        chk(partitioned, 1'b1, "R7 repartition at 32");
    endtask

    task automatic t_disable();
        do_reset();
        cfg_disable = 1'b1;
        colls(100);
        chk(partitioned, 1'b0, "R9 disabled never partitions");
        cfg_disable = 1'b0;
        colls(32);
        chk(partitioned, 1'b1, "R9 setup partitioned");
        @(negedge clk); cfg_disable = 1'b1;
        @(negedge clk);
        chk(partitioned, 1'b0, "R9 disable clears partition");
        cfg_disable = 1'b0;
        colls(31);
        chk(partitioned, 1'b0, "R9 disable cleared count");
    endtask

    task automatic t_no_strobe();
        do_reset();
        colls(31);
        @(negedge clk); pkt_coll = 1'b1; pkt_tx = 1'b1; pkt_long = 1'b1;
        repeat (5) @(negedge clk);
        pkt_coll = 1'b0; pkt_tx = 1'b0; pkt_long = 1'b0;
        chk(partitioned, 1'b0, "R10 collision without strobe ignored");
        colls(1);
        chk(partitioned, 1'b1, "R10 count intact, 32nd partitions");
        @(negedge clk); pkt_tx = 1'b1; pkt_long = 1'b1;
        repeat (3) @(negedge clk);
        pkt_tx = 1'b0; pkt_long = 1'b0;
        chk(partitioned, 1'b1, "R10 unstrobed clean tx ignored");
    endtask

    initial begin
        rst = 1'b1; pkt_end = 1'b0; pkt_coll = 1'b0; pkt_tx = 1'b0; pkt_long = 1'b0;
        cfg_limit_hi = 1'b0; cfg_disable = 1'b0; rx_active = 1'b0;
        t_reset();
        t_limit_lo();
        t_limit_hi();
        t_clean_resets();
        t_rejoin();
        t_disable();
        t_no_strobe();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule